// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits in a bit-oriented receiver between the stage that strips flags and removes stuffed zeros and the receive FIFO. Each frame reaches it as a start marker, then a run of byte strobes, then an end marker or an abort. When the link runs in bit-oriented mode with station filtering switched on, the first byte after the start marker is the station address. It is compared against a programmed address and against the all-ones broadcast value. A matching frame is passed on byte for byte. A non-matching frame is dropped without any output, and the block stays idle until the next start marker.

A 16-bit CRC is kept over every byte passed on, address byte included. Flags never enter it because they never reach this block. On the end marker of an accepted frame, the block raises a one-clock completion pulse that carries a good/bad verdict. Dropping the receiver enable returns the block to hunt and resets the CRC.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset, and while in hunt with no start marker seen, `out_vld`, `frm_done` and `frm_crc_ok` stay low, and byte strobes produce no output.
- R2: With filtering active (`sdlc_mode`=1 and `addr_search_en`=1), a frame whose first byte equals `station_addr` is accepted. Each byte of the frame, the address byte included, appears on `out_dat` with `out_vld` high one clock after its input strobe.
- R3: With filtering active, a first byte of 8'hFF is accepted whatever value `station_addr` holds.
- R4: With filtering active, a frame whose first byte matches neither `station_addr` nor 8'hFF gives no `out_vld` for any of its bytes and no `frm_done` at its end.
- R5: Filtering applies only when `sdlc_mode`=1. If either `sdlc_mode` or `addr_search_en` is 0, every frame is accepted whatever its first byte.
- R6: The CRC uses the polynomial x^16+x^12+x^5+1 in reflected form (0x8408), preset to 16'hFFFF, with each byte fed least significant bit first. The end marker of an accepted frame gives `frm_done` high for one clock, one clock later. `frm_crc_ok` is 1 in that clock exactly when `crc_en` was 1 and the register holds 16'hF0B8.
- R7: An end marker or abort while a rejected frame is being discarded returns the block to hunt, and the next frame is filtered normally.
- R8: An abort during an accepted frame ends it with no `frm_done`.
- R9: While `rx_on` is 0 the block holds hunt with the CRC at its preset, and `out_vld` and `frm_done` stay low.
- R10: A start marker in any state restarts address checking and the CRC, so the frame that follows is judged on its own bytes only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_on | input | 1 | Receiver enable; low forces hunt and clears the CRC |
| sdlc_mode | input | 1 | 1 selects bit-oriented framing, where filtering can apply |
| addr_search_en | input | 1 | Station address filtering enable |
| crc_en | input | 1 | CRC accumulation enable |
| station_addr | input | 8 | Programmed station address |
| sof | input | 1 | Start-of-frame marker (one clock) |
| eof | input | 1 | Closing flag seen (one clock) |
| abort | input | 1 | Frame aborted (one clock) |
| byte_vld | input | 1 | Byte strobe |
| byte_dat | input | 8 | Received byte, bit 0 first on the line |
| out_vld | output | 1 | Forwarded byte strobe toward the FIFO |
| out_dat | output | 8 | Forwarded byte |
| frm_done | output | 1 | End of an accepted frame (one clock) |
| frm_crc_ok | output | 1 | CRC verdict, valid with `frm_done` |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, broadcast value 8'hFF, a 16-bit CRC with preset 16'hFFFF and good residue 16'hF0B8. With these values, any frame the bench builds with its own byte-wide CRC routine should end with a good verdict. A single flipped FCS bit should give a bad one. Because the broadcast value sits at the top of the byte range, station addresses of 8'h00 and 8'hFF both fall within the table. This covers the case where the programmed address equals the broadcast value, so a frame addressed elsewhere must still be dropped.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_ADDR = 2'd1,
    ST_PASS = 2'd2,
    ST_DROP = 2'd3
  } af_state_e;

  // One byte through a reflected CRC, bit 0 of the byte first.
  function automatic logic [CRC_W-1:0] crc_byte_step(
    input logic [CRC_W-1:0]  cur,
    input logic [BYTE_W-1:0] dat,
    input logic [CRC_W-1:0]  poly_r
  );
    logic [CRC_W-1:0] acc;
    logic             fb;
    acc = cur;
    for (int i = 0; i < BYTE_W; i++) begin
      fb  = acc[0] ^ dat[i];
      acc = acc >> 1;
      if (fb) acc = acc ^ poly_r;
    end
    return acc;
  endfunction

endpackage

// File: rtl/hdlc_af_addr_match.sv
module hdlc_af_addr_match #(
  parameter int               BYTE_W = 8,
  parameter logic [BYTE_W-1:0] BCAST = '1
) (
  input  logic              search_on,
  input  logic              test_en,
  input  logic [BYTE_W-1:0] first_byte,
  input  logic [BYTE_W-1:0] station,
  output logic              hit,
  output logic              miss
);
  logic is_match;

  always_comb begin
    is_match = (first_byte == station) || (first_byte == BCAST);
    hit      = test_en && (!search_on || is_match);
    miss     = test_en && search_on && !is_match;
  end
endmodule

// File: rtl/hdlc_af_crc.sv
module hdlc_af_crc
  import hdlc_af_pkg::*;
#(
  parameter int               CW     = CRC_W,
  parameter logic [CW-1:0]    POLY_R = 16'h8408,
  parameter logic [CW-1:0]    PRESET = 16'hFFFF,
  parameter logic [CW-1:0]    GOOD   = 16'hF0B8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [BYTE_W-1:0] dat,
  output logic [CW-1:0]     crc_q,
  output logic              crc_good
);
  always_ff @(posedge clk) begin
    if (!rst_n)   crc_q <= PRESET;
    else if (clr) crc_q <= PRESET;
    else if (upd) crc_q <= crc_byte_step(crc_q, dat, POLY_R);
  end

  assign crc_good = (crc_q == GOOD);
endmodule

// File: rtl/hdlc_af_ctrl.sv
module hdlc_af_ctrl
  import hdlc_af_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rx_on,
  input  logic      sof,
  input  logic      eof,
  input  logic      abort,
  input  logic      byte_vld,
  input  logic      hit,
  input  logic      miss,
  output af_state_e state,
  output logic      test_en,
  output logic      fwd,
  output logic      end_ok,
  output logic      crc_clr
);
  logic byte_take;

  always_comb begin
    // A byte counts only when no marker shares its clock.
    byte_take = rx_on && byte_vld && !sof && !eof && !abort;
    test_en   = byte_take && (state == ST_ADDR);
    fwd       = byte_take && ((state == ST_PASS) || hit);
    end_ok    = rx_on && eof && !sof && (state == ST_PASS);
    crc_clr   = !rx_on || sof;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              state <= ST_HUNT;
    else if (!rx_on)         state <= ST_HUNT;
    else if (sof)            state <= ST_ADDR;
    else if (abort || eof)   state <= ST_HUNT;
    else if (test_en && hit) state <= ST_PASS;
    else if (miss)           state <= ST_DROP;
  end
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_af_pkg::*;
#(
  parameter logic [BYTE_W-1:0] BCAST_ADDR = 8'hFF,
  parameter logic [CRC_W-1:0]  CRC_POLY_R = 16'h8408,
  parameter logic [CRC_W-1:0]  CRC_PRESET = 16'hFFFF,
  parameter logic [CRC_W-1:0]  CRC_GOOD   = 16'hF0B8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_on,
  input  logic              sdlc_mode,
  input  logic              addr_search_en,
  input  logic              crc_en,
  input  logic [BYTE_W-1:0] station_addr,
  input  logic              sof,
  input  logic              eof,
  input  logic              abort,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_dat,
  output logic              out_vld,
  output logic [BYTE_W-1:0] out_dat,
  output logic              frm_done,
  output logic              frm_crc_ok
);
  af_state_e        state;
  logic             search_on;
  logic             test_en;
  logic             addr_hit;
  logic             addr_miss;
  logic             fwd;
  logic             end_ok;
  logic             crc_clr;
  logic             crc_good;
  logic [CRC_W-1:0] crc_q;
  logic             in_drop;
  logic             in_hunt;

  assign search_on = sdlc_mode && addr_search_en;
  assign in_drop   = (state == ST_DROP);
  assign in_hunt   = (state == ST_HUNT);

  hdlc_af_addr_match #(.BYTE_W(BYTE_W), .BCAST(BCAST_ADDR)) match_i (
    .search_on (search_on),
    .test_en   (test_en),
    .first_byte(byte_dat),
    .station   (station_addr),
    .hit       (addr_hit),
    .miss      (addr_miss)
  );

  hdlc_af_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_on   (rx_on),
    .sof     (sof),
    .eof     (eof),
    .abort   (abort),
    .byte_vld(byte_vld),
    .hit     (addr_hit),
    .miss    (addr_miss),
    .state   (state),
    .test_en (test_en),
    .fwd     (fwd),
    .end_ok  (end_ok),
    .crc_clr (crc_clr)
  );

  hdlc_af_crc #(
    .CW(CRC_W), .POLY_R(CRC_POLY_R), .PRESET(CRC_PRESET), .GOOD(CRC_GOOD)
  ) crc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (crc_clr),
    .upd     (fwd && crc_en),
    .dat     (byte_dat),
    .crc_q   (crc_q),
    .crc_good(crc_good)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld    <= 1'b0;
      out_dat    <= '0;
      frm_done   <= 1'b0;
      frm_crc_ok <= 1'b0;
    end else begin
      out_vld    <= fwd;
      if (fwd) out_dat <= byte_dat;
      frm_done   <= end_ok;
      frm_crc_ok <= end_ok && crc_en && crc_good;
    end
  end
endmodule

// File: rtl/hdlc_af_chk.sv
module hdlc_af_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_on,
  input logic              sof,
  input logic              eof,
  input logic              abort,
  input logic              crc_en,
  input logic              byte_vld,
  input logic [BYTE_W-1:0] byte_dat,
  input logic              out_vld,
  input logic [BYTE_W-1:0] out_dat,
  input logic              frm_done,
  input logic              frm_crc_ok,
  input logic              addr_hit,
  input logic              addr_miss,
  input logic              in_drop,
  input logic              in_hunt
);
  p_fwd_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ($past(byte_vld) && out_dat == $past(byte_dat)));

  p_hit_miss_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_hit, addr_miss}));

  p_miss_to_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> in_drop);

  p_no_fwd_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_drop && byte_vld && !sof) |=> !out_vld);

  p_done_after_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> $past(eof));

  p_ok_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frm_crc_ok |-> (frm_done && $past(crc_en)));

  p_drop_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_drop && rx_on && !sof && (eof || abort)) |=> in_hunt);

  p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !frm_done);

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_on |=> (!out_vld && !frm_done && in_hunt));
endmodule

bind hdlc_addr_filter hdlc_af_chk #(.BYTE_W(8)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_on     (rx_on),
  .sof       (sof),
  .eof       (eof),
  .abort     (abort),
  .crc_en    (crc_en),
  .byte_vld  (byte_vld),
  .byte_dat  (byte_dat),
  .out_vld   (out_vld),
  .out_dat   (out_dat),
  .frm_done  (frm_done),
  .frm_crc_ok(frm_crc_ok),
  .addr_hit  (addr_hit),
  .addr_miss (addr_miss),
  .in_drop   (in_drop),
  .in_hunt   (in_hunt)
);

// File: tb/hdlc_addr_filter_tb_top.sv
module hdlc_addr_filter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_on = 1'b0, sdlc_mode = 1'b1, addr_search_en = 1'b1, crc_en = 1'b1;
  logic [7:0] station_addr = 8'h00;
  logic       sof = 1'b0, eof = 1'b0, abort = 1'b0, byte_vld = 1'b0;
  logic [7:0] byte_dat = 8'h00;
  logic       out_vld, frm_done, frm_crc_ok;
  logic [7:0] out_dat;

  int n_tests = 0;
  int n_fail  = 0;
  int n_rx    = 0;
  int n_done  = 0;
  int n_ok    = 0;
  logic [7:0] rx_buf [16];

  always #4 clk = ~clk;

  hdlc_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .sdlc_mode(sdlc_mode),
    .addr_search_en(addr_search_en), .crc_en(crc_en), .station_addr(station_addr),
    .sof(sof), .eof(eof), .abort(abort), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .out_vld(out_vld), .out_dat(out_dat), .frm_done(frm_done), .frm_crc_ok(frm_crc_ok)
  );

  // Vector: {station, first byte, sdlc_mode, addr_search_en, accept expected}
  localparam logic [18:0] VEC [7] = '{
    {8'h42, 8'h42, 1'b1, 1'b1, 1'b1},   // R2 own address
    {8'h42, 8'hFF, 1'b1, 1'b1, 1'b1},   // R3 broadcast
    {8'h42, 8'h43, 1'b1, 1'b1, 1'b0},   // R4 mismatch
    {8'h42, 8'h43, 1'b0, 1'b1, 1'b1},   // R5 not bit-oriented mode
    {8'h42, 8'h43, 1'b1, 1'b0, 1'b1},   // R5 search off
    {8'h00, 8'hFF, 1'b1, 1'b1, 1'b1},   // R3 broadcast, zero station
    {8'hFF, 8'h10, 1'b1, 1'b1, 1'b0}    // R4 station equals broadcast
  };

  // Byte-wide form of the reflected CCITT update.
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = d ^ c[7:0];
    x = x ^ (x << 4);
    return (c >> 8) ^ {x, 8'h00} ^ {5'b0, x, 3'b0} ^ {12'b0, x[7:4]};
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_vld) begin
        if (n_rx < 16) rx_buf[n_rx] = out_dat;
        n_rx++;
      end
      if (frm_done) begin
        n_done++;
        if (frm_crc_ok) n_ok++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    n_rx = 0; n_done = 0; n_ok = 0;
  endtask

  task automatic pulse_sof();   sof = 1'b1;   @(negedge clk); sof = 1'b0;   endtask
  task automatic pulse_eof();   eof = 1'b1;   @(negedge clk); eof = 1'b0;   endtask
  task automatic pulse_abort(); abort = 1'b1; @(negedge clk); abort = 1'b0; endtask
  task automatic put_byte(input logic [7:0] b);
    byte_vld = 1'b1; byte_dat = b; @(negedge clk); byte_vld = 1'b0;
  endtask

  // sof, three payload bytes, FCS low then high; eof left to the caller.
  task automatic send_body(input logic [7:0] a, input logic [7:0] d1,
                           input logic [7:0] d2, input bit corrupt);
    logic [15:0] c;
    c = 16'hFFFF;
    c = ref_crc(c, a); c = ref_crc(c, d1); c = ref_crc(c, d2);
    c = ~c;
    if (corrupt) c[3] = ~c[3];
    pulse_sof();
    put_byte(a); put_byte(d1); put_byte(d2);
    put_byte(c[7:0]); put_byte(c[15:8]);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset out_vld", int'(out_vld), 0);
    chk("R1 reset frm_done", int'(frm_done), 0);
    rst_n = 1'b1; rx_on = 1'b1;
    @(negedge clk);
    clr_mon();
    put_byte(8'h42); put_byte(8'h11); pulse_eof();
    @(negedge clk);
    chk("R1 hunt bytes", n_rx, 0);
    chk("R1 hunt done", n_done, 0);

    for (int i = 0; i < 7; i++) begin
      logic [18:0] v;
      v = VEC[i];
      station_addr = v[18:11]; sdlc_mode = v[2]; addr_search_en = v[1];
      clr_mon();
      send_body(v[10:3], 8'(8'h11 * i), 8'hA5, 1'b0);
      pulse_eof();
      @(negedge clk); @(negedge clk);
      if (v[0]) begin
        chk($sformatf("R2/R3/R5 vec%0d bytes", i), n_rx, 5);
        chk($sformatf("R2 vec%0d first", i), int'(rx_buf[0]), int'(v[10:3]));
        chk($sformatf("R6 vec%0d done", i), n_done, 1);
        chk($sformatf("R6 vec%0d ok", i), n_ok, 1);
      end else begin
        chk($sformatf("R4 vec%0d bytes", i), n_rx, 0);
        chk($sformatf("R4 vec%0d done", i), n_done, 0);
      end
    end

    station_addr = 8'h42; sdlc_mode = 1'b1; addr_search_en = 1'b1;
    // R6 corrupted FCS
    clr_mon();
    send_body(8'h42, 8'h01, 8'h02, 1'b1); pulse_eof(); @(negedge clk);
    chk("R6 bad fcs done", n_done, 1);
    chk("R6 bad fcs ok", n_ok, 0);
    // R6 crc disabled
    crc_en = 1'b0; clr_mon();
    send_body(8'h42, 8'h01, 8'h02, 1'b0); pulse_eof(); @(negedge clk);
    chk("R6 crc off done", n_done, 1);
    chk("R6 crc off ok", n_ok, 0);
    crc_en = 1'b1;

    // R7 abort while discarding, next frame accepted
    clr_mon();
    pulse_sof(); put_byte(8'h55); put_byte(8'h66); pulse_abort();
    put_byte(8'h42); @(negedge clk);
    chk("R7 discard silent", n_rx, 0);
    send_body(8'h42, 8'h07, 8'h08, 1'b0); pulse_eof(); @(negedge clk);
    chk("R7 next frame bytes", n_rx, 5);
    chk("R7 next frame ok", n_ok, 1);

    // R8 abort during accepted frame
    clr_mon();
    pulse_sof(); put_byte(8'h42); put_byte(8'h09); pulse_abort(); pulse_eof();
    @(negedge clk);
    chk("R8 bytes before abort", n_rx, 2);
    chk("R8 no done", n_done, 0);

    // R9 receiver off mid-frame
    clr_mon();
    pulse_sof(); put_byte(8'h42);
    rx_on = 1'b0;
    put_byte(8'h33); pulse_sof(); put_byte(8'h42); pulse_eof();
    @(negedge clk);
    chk("R9 off bytes", n_rx, 1);
    chk("R9 off done", n_done, 0);
    rx_on = 1'b1; @(negedge clk);
    put_byte(8'h42); @(negedge clk);
    chk("R9 hunt after enable", n_rx, 1);

    // R10 restart by a new start marker
    clr_mon();
    pulse_sof(); put_byte(8'h42); put_byte(8'hDE);
    send_body(8'hFF, 8'h0A, 8'h0B, 1'b0); pulse_eof(); @(negedge clk);
    chk("R10 bytes", n_rx, 7);
    chk("R10 ok", n_ok, 1);
    clr_mon();
    pulse_sof(); put_byte(8'h42);
    pulse_sof(); put_byte(8'h99); put_byte(8'h42); pulse_eof(); @(negedge clk);
    chk("R10 rejudged drop", n_rx, 1);
    chk("R10 rejudged done", n_done, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule